// File: doc/BRIEF.md
# Beam-Synchronised Display List Coprocessor

This block runs a short program of two-word instructions stored in memory. It keeps that program in step with the video beam. Each instruction does one of three things:

- it writes a 16-bit value into one of a bank of chipset registers;
- it stalls until the beam counters reach a programmed position, and can also wait for the blitter to go idle;
- it skips the following instruction when that position has already passed.

At the start of every frame a pulse restarts the program from a list pointer given at an input. The coprocessor moves through fetch, execute and beam-wait phases. A fourth, halted phase is entered at reset and on a stop instruction, and is left only by the next frame pulse.

Words are read through a plain request/grant port. A slot arbiter outside the block decides when each word may be taken. The word is captured in the cycle its grant is seen. Register writes leave on a one-cycle write strobe with a register number and a data word.

Top module: `dlist_engine`

## Requirements
- R1: After reset, mem_req and reg_we stay low until the first frame_start pulse.
- R2: Each instruction is two 16-bit words read from consecutive word addresses, starting at list_base. While a request waits for mem_gnt, mem_req stays high and mem_addr holds still. mem_rdata is taken in the cycle mem_gnt is high.
- R3: A first word with bit 0 clear is a register write. In the cycle after the second word is granted, reg_we pulses for one cycle, with reg_sel equal to first word bits 8:1 and reg_wdata equal to the second word.
- R4: When first word bit 0 is set, the instruction is a position test, and its fields are laid out as follows. The first word bits 15:8 give the vertical target and bits 7:1 give horizontal bits 7:1. In the second word, bit 0 is 0 for wait and 1 for skip, bits 14:8 mask vertical bits 6:0, and bits 7:1 mask horizontal bits 7:1. Vertical bit 7 is always compared. The position counts as reached when the masked {beam_v, beam_h[7:1]} is greater than or equal to the masked target.
- R5: A wait holds the program, with no memory request and no write, until the position is reached. Fetching then resumes with the next instruction.
- R6: Second word bit 15 clear makes both a wait and a skip also require blit_busy to be low; bit 15 set ignores blit_busy.
- R7: A skip whose condition is met passes over the next instruction without executing it. A skip whose condition is not met continues with the next instruction.
- R8: The wait with first word 0xFFFF and second word 0xFFFE never completes. After it, no further requests or writes occur until frame_start, whatever the beam position.
- R9: frame_start restarts the program from list_base from any phase, including a wait or a halt. mem_req is high with mem_addr equal to list_base in the following cycle.
- R10: A frame_start in the execute cycle of a register write suppresses that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| list_base | input | ADDR_W | Word address of the first instruction |
| mem_req | output | 1 | Instruction word read request |
| mem_addr | output | ADDR_W | Word address of the requested word |
| mem_gnt | input | 1 | Arbiter grant; data valid in the same cycle |
| mem_rdata | input | 16 | Read data |
| beam_v | input | 8 | Vertical beam position, low bits |
| beam_h | input | 8 | Horizontal beam position |
| blit_busy | input | 1 | Blitter operation in progress |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | SEL_W | Target register number |
| reg_wdata | output | 16 | Value written |

## Verification
The frame restart and the register-write strobe can fall in the same cycle. This is the one place where a frame boundary must win over a write that has already been fully fetched.

The bench provokes it by granting every request. It counts the two grant cycles after a frame pulse and raises a second pulse exactly in the execute cycle. The write log must then hold each write of the list exactly once: the interrupted write is absent, and it reappears only because the restarted list runs it again.

// File: rtl/dlist_engine.sv
module dlist_engine #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] list_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [15:0]       mem_rdata,
  input  logic [7:0]        beam_v,
  input  logic [7:0]        beam_h,
  input  logic              blit_busy,
  output logic              reg_we,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [15:0]       reg_wdata
);
  localparam int CMP_W = 15;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT} st_t;

  st_t               state;
  logic [ADDR_W-1:0] pc;
  logic [15:0]       w0, w1;
  logic              second;

  logic             is_test, is_skip, is_stop, blit_ok, hit;
  logic [CMP_W-1:0] mask, cur, tgt;

  assign is_test = w0[0];
  assign is_skip = w1[0];
  assign is_stop = (w0 == 16'hFFFF) && (w1 == 16'hFFFE);
  assign mask    = {1'b1, w1[14:8], w1[7:1]};
  assign cur     = {beam_v, beam_h[7:1]} & mask;
  assign tgt     = {w0[15:8], w0[7:1]} & mask;
  assign blit_ok = w1[15] || !blit_busy;
  assign hit     = (cur >= tgt) && blit_ok;

  assign mem_req   = (state == ST_FETCH);
  assign mem_addr  = pc;
  assign reg_we    = (state == ST_EXEC) && !is_test && !frame_start;
  assign reg_sel   = w0[SEL_W:1];
  assign reg_wdata = w1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pc     <= '0;
      w0     <= '0;
      w1     <= '0;
      second <= 1'b0;
    end else if (frame_start) begin
      state  <= ST_FETCH;
      pc     <= list_base;
      second <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: if (mem_gnt) begin
          pc <= pc + 1'b1;
          if (!second) begin
            w0     <= mem_rdata;
            second <= 1'b1;
          end else begin
            w1     <= mem_rdata;
            second <= 1'b0;
            state  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (!is_test)
            state <= ST_FETCH;
          else if (is_stop)
            state <= ST_IDLE;
          else if (is_skip) begin
            if (hit) pc <= pc + ADDR_W'(2);
            state <= ST_FETCH;
          end else
            state <= hit ? ST_FETCH : ST_WAIT;
        end
        ST_WAIT: if (hit) state <= ST_FETCH;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlist_engine_chk.sv
module dlist_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [ADDR_W-1:0] list_base,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              reg_we
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !frame_start) |=> (mem_req && $stable(mem_addr)));

  p_write_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(mem_gnt));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mem_req && mem_addr == $past(list_base)));

  p_frame_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !reg_we);

  p_no_fetch_while_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && reg_we));
endmodule

bind dlist_engine dlist_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .list_base(list_base),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .reg_we(reg_we)
);

// File: tb/dlist_engine_tb.sv
module dlist_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [15:0] list_base = '0;
  logic        mem_req, mem_gnt, reg_we;
  logic [15:0] mem_addr, mem_rdata, reg_wdata;
  logic [7:0]  beam_v = '0, beam_h = '0, reg_sel;
  logic        blit_busy = 1'b0;
  logic        gnt_hold = 1'b0, gnt_slow = 1'b0;
  logic [1:0]  gnt_cnt = '0;

  logic [15:0] mem [0:255];
  int checks = 0, fails = 0;
  int log_n = 0;
  logic [7:0]  log_sel [0:31];
  logic [15:0] log_dat [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_gnt   = gnt_hold ? 1'b0 : (gnt_slow ? (gnt_cnt == 2'b00) : 1'b1);
  always @(posedge clk) gnt_cnt <= gnt_cnt + 2'd1;

  always @(negedge clk) if (reg_we && log_n < 32) begin
    log_sel[log_n] = reg_sel;
    log_dat[log_n] = reg_wdata;
    log_n = log_n + 1;
  end

  dlist_engine dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .list_base(list_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .beam_v(beam_v), .beam_h(beam_h), .blit_busy(blit_busy),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_frame(input logic [15:0] base);
    @(posedge clk); #1 list_base = base; frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
  endtask

  task automatic put(input int a, input logic [15:0] x, input logic [15:0] y);
    mem[a] = x;
    mem[a+1] = y;
  endtask

  task automatic put_move(input int a, input logic [7:0] sel, input logic [15:0] d);
    put(a, {7'b0, sel, 1'b0}, d);
  endtask

  task automatic put_stop(input int a);
    put(a, 16'hFFFF, 16'hFFFE);
  endtask

  task automatic chk_log(input int idx, input logic [7:0] sel, input logic [15:0] d, input string req);
    chk(log_sel[idx] == sel, req, log_sel[idx], sel);
    chk(log_dat[idx] == d, req, log_dat[idx], d);
  endtask

  task automatic t_reset;
    run(3);
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    rst_n = 1'b1;
    run(6);
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    chk(log_n == 0, "R1", log_n, 0);
  endtask

  task automatic t_moves(input bit slow);
    gnt_slow = slow;
    put_move(8'h00, 8'h0A, 16'h1111);
    put_move(8'h02, 8'h7F, 16'h2222);
    put_move(8'h04, 8'hFF, 16'hF00D);
    put_stop(8'h06);
    log_n = 0;
    pulse_frame(16'h0000);
    run(60);
    chk(log_n == 3, "R3", log_n, 3);
    chk_log(0, 8'h0A, 16'h1111, "R3");
    chk_log(1, 8'h7F, 16'h2222, "R2");
    chk_log(2, 8'hFF, 16'hF00D, "R3");
    gnt_slow = 1'b0;
  endtask

  task automatic t_grant_stall;
    put_move(8'h60, 8'h40, 16'hCAFE);
    put_stop(8'h62);
    log_n = 0;
    gnt_hold = 1'b1;
    pulse_frame(16'h0060);
    run(6);
    chk(mem_req == 1'b1, "R2", mem_req, 1);
    chk(mem_addr == 16'h0060, "R2", mem_addr, 16'h60);
    chk(log_n == 0, "R2", log_n, 0);
    gnt_hold = 1'b0;
    run(10);
    chk(log_n == 1, "R2", log_n, 1);
    chk_log(0, 8'h40, 16'hCAFE, "R2");
  endtask

  task automatic t_wait;
    put(8'h10, 16'h1041, 16'hFFFE);
    put_move(8'h12, 8'h05, 16'h1234);
    put_stop(8'h14);
    beam_v = 8'h05; beam_h = 8'h00;
    log_n = 0;
    pulse_frame(16'h0010);
    run(20);
    chk(log_n == 0, "R5", log_n, 0);
    chk(mem_req == 1'b0, "R5", mem_req, 0);
    beam_v = 8'h10; beam_h = 8'h3E;
    run(10);
    chk(log_n == 0, "R4", log_n, 0);
    beam_h = 8'h41;
    run(10);
    chk(log_n == 1, "R5", log_n, 1);
    chk_log(0, 8'h05, 16'h1234, "R5");
  endtask

  task automatic t_mask;
    put(8'h70, 16'h20FF, 16'hFF00);
    put_move(8'h72, 8'h06, 16'h5678);
    put_stop(8'h74);
    beam_v = 8'h1F; beam_h = 8'hFF;
    log_n = 0;
    pulse_frame(16'h0070);
    run(15);
    chk(log_n == 0, "R4", log_n, 0);
    beam_v = 8'h20; beam_h = 8'h00;
    run(10);
    chk(log_n == 1, "R4", log_n, 1);
  endtask

  task automatic t_blit;
    put(8'h80, 16'h0001, 16'h7FFE);
    put_move(8'h82, 8'h07, 16'h9ABC);
    put_stop(8'h84);
    beam_v = 8'h50; blit_busy = 1'b1;
    log_n = 0;
    pulse_frame(16'h0080);
    run(15);
    chk(log_n == 0, "R6", log_n, 0);
    blit_busy = 1'b0;
    run(10);
    chk(log_n == 1, "R6", log_n, 1);
    put(8'h80, 16'h0001, 16'hFFFE);
    blit_busy = 1'b1;
    log_n = 0;
    pulse_frame(16'h0080);
    run(15);
    chk(log_n == 1, "R6", log_n, 1);
    blit_busy = 1'b0;
  endtask

  task automatic t_skip;
    put(8'h50, 16'h3001, 16'hFFFF);
    put_move(8'h52, 8'h31, 16'h0031);
    put_move(8'h54, 8'h32, 16'h0032);
    put_stop(8'h56);
    beam_v = 8'h40;
    log_n = 0;
    pulse_frame(16'h0050);
    run(25);
    chk(log_n == 1, "R7", log_n, 1);
    chk_log(0, 8'h32, 16'h0032, "R7");
    beam_v = 8'h20;
    log_n = 0;
    pulse_frame(16'h0050);
    run(25);
    chk(log_n == 2, "R7", log_n, 2);
    chk_log(0, 8'h31, 16'h0031, "R7");
  endtask

  task automatic t_stop;
    put_stop(8'h20);
    put_move(8'h22, 8'h01, 16'h0001);
    beam_v = 8'hFF; beam_h = 8'hFF;
    log_n = 0;
    pulse_frame(16'h0020);
    run(10);
    chk(mem_req == 1'b0, "R8", mem_req, 0);
    run(20);
    chk(log_n == 0, "R8", log_n, 0);
    chk(mem_req == 1'b0, "R8", mem_req, 0);
  endtask

  task automatic t_restart;
    put_move(8'h30, 8'h22, 16'h2222);
    put_stop(8'h32);
    log_n = 0;
    pulse_frame(16'h0030);
    run(10);
    chk(log_n == 1, "R9", log_n, 1);
    beam_v = 8'h00; beam_h = 8'h00;
    log_n = 0;
    pulse_frame(16'h0010);
    run(10);
    chk(mem_req == 1'b0, "R9", mem_req, 0);
    pulse_frame(16'h0030);
    run(10);
    chk(log_n == 1, "R9", log_n, 1);
    chk_log(0, 8'h22, 16'h2222, "R9");
  endtask

  task automatic t_collision;
    put_move(8'h40, 8'h11, 16'hAAAA);
    put_move(8'h42, 8'h12, 16'hBBBB);
    put_stop(8'h44);
    log_n = 0;
    pulse_frame(16'h0040);
    @(posedge clk); #1;
    @(posedge clk); #1 frame_start = 1'b1;
    @(posedge clk); #1 frame_start = 1'b0;
    run(20);
    chk(log_n == 2, "R10", log_n, 2);
    chk_log(0, 8'h11, 16'hAAAA, "R10");
    chk_log(1, 8'h12, 16'hBBBB, "R10");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    t_reset();
    t_moves(1'b0);
    t_moves(1'b1);
    t_grant_stall();
    t_wait();
    t_mask();
    t_blit();
    t_skip();
    t_stop();
    t_restart();
    t_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule